// File: doc/BRIEF.md
# Hot-Swap Gate Control Sequencer

This block is the digital control core of a hot-swap controller for a card that plugs into a live supply backplane. It decides when the external pass transistor may be switched on. It also reports when the load is fully powered and when repeated short circuits have made it give up. The analog parts (comparators, gate slew and gate current) stay outside. They reach the block as single-bit flags, and each flag is resynchronised into the block clock.

After power-on reset the block waits until the supply has stayed inside the voltage window for a hold-off interval, and only then enables the gate. While the load is charging, only the high insertion overcurrent flag can trip the circuit breaker. Once power-good is up, the normal flag takes over. A trip must persist through a noise filter. After a trip the gate stays off for a retry interval and is then re-enabled. A build parameter either bounds the number of retries or lets them continue without limit. The host can pull the gate off with its insertion/extraction control. A long enough pulse on that control restarts the whole start-up sequence and clears the retry history.

All intervals are given in microseconds and counted in periods of an external timebase tick whose period is a parameter.

Top module: `hs_gate_seq`

## Requirements
- R1: While reset is asserted and directly after it, `gate_en`, `pwr_good` and `retry_fail` are 0.
- R2: After reset or a restart, `gate_en` rises only once both voltage flags have been low for HOLD_US without a break. Any undervoltage or overvoltage flag during that time starts the hold-off again from zero.
- R3: When `uv_flag` or `ov_flag` goes high, `gate_en` falls within 4 clock cycles. When both flags clear again, `gate_en` returns within 4 cycles without a new hold-off.
- R4: While `pwr_good` is 0, only `oc_ins_flag` can trip the breaker and `oc_norm_flag` is ignored. While `pwr_good` is 1, `oc_norm_flag` trips it.
- R5: The selected overcurrent flag turns the gate off only after it has been high for FILT_US without a break. Shorter pulses leave `gate_en` at 1.
- R6: `pwr_good` is 1 only when both `drain_ok` and `gate_ok` are 1. It follows a change of either input within 4 clock cycles.
- R7: After an overcurrent trip, `gate_en` stays 0 for RETRY_US and then returns to 1.
- R8: With RETRY_LIMIT = N > 0, the trip that follows the N-th retry leaves the gate off for good and sets `retry_fail`. With RETRY_LIMIT = 0 the block retries without end and `retry_fail` stays 0.
- R9: `retry_fail` and the retry count clear only on reset or on an accepted `mrh` pulse. Removing the fault does not clear them.
- R10: A high `mrh` forces `gate_en` to 0 within 4 cycles. A pulse shorter than MRH_US lets the gate come back without a hold-off. A pulse of at least MRH_US is accepted: when `mrh` is released, the hold-off of R2 starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Timebase pulse, one per TICK_US |
| uv_flag | input | 1 | Undervoltage comparator, 1 = supply too low |
| ov_flag | input | 1 | Overvoltage comparator, 1 = supply too high |
| oc_norm_flag | input | 1 | Normal overcurrent comparator |
| oc_ins_flag | input | 1 | Insertion (higher) overcurrent comparator |
| drain_ok | input | 1 | Drain voltage good flag |
| gate_ok | input | 1 | Gate voltage good flag |
| mrh | input | 1 | Host insertion/extraction control, 1 = hold gate off |
| gate_en | output | 1 | Pass transistor gate enable |
| pwr_good | output | 1 | Load powered indication |
| retry_fail | output | 1 | Retry limit exhausted |

## Verification
The hardest state to reach is the exhausted retry budget. It takes a fault held through several complete trip–wait–retry loops, each one of which must first rebuild the filter count after the gate comes back. The bench keeps the normal overcurrent flag high after power-good has been established, and lets the loops run out in a bounded window. A second instance with the unbounded mode shares the same stimulus. The bench then confirms that the failure persists after the fault is removed and that only an accepted host pulse clears it.

// File: rtl/hs_gate_pkg.sv
package hs_gate_pkg;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_ON    = 3'd1,
    ST_RETRY = 3'd2,
    ST_FAIL  = 3'd3,
    ST_MRH   = 3'd4
  } hs_state_e;

  // Number of timebase ticks needed to cover a delay, rounded up, at least one.
  function automatic int unsigned us_to_ticks(input int unsigned us, input int unsigned tick_us);
    int unsigned t;
    t = (us + tick_us - 1) / tick_us;
    return (t == 0) ? 1 : t;
  endfunction

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs_persist.sv
module hs_persist
  import hs_gate_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic din,
  output logic hit
);
  localparam int unsigned CW = cnt_width(N);
  localparam logic [CW-1:0] LIM = CW'(N);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr || !din)       cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == LIM);

  AST_PERSIST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(din)); // R5
endmodule

// File: rtl/hs_gate_seq.sv
module hs_gate_seq
  import hs_gate_pkg::*;
#(
  parameter int unsigned TICK_US     = 1,
  parameter int unsigned HOLD_US     = 50000,
  parameter int unsigned RETRY_US    = 100000,
  parameter int unsigned FILT_US     = 5,
  parameter int unsigned MRH_US      = 5,
  parameter int unsigned RETRY_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic uv_flag,
  input  logic ov_flag,
  input  logic oc_norm_flag,
  input  logic oc_ins_flag,
  input  logic drain_ok,
  input  logic gate_ok,
  input  logic mrh,
  output logic gate_en,
  output logic pwr_good,
  output logic retry_fail
);
  localparam int unsigned HOLD_T  = us_to_ticks(HOLD_US, TICK_US);
  localparam int unsigned RETRY_T = us_to_ticks(RETRY_US, TICK_US);
  localparam int unsigned FILT_T  = us_to_ticks(FILT_US, TICK_US);
  localparam int unsigned MRH_T   = us_to_ticks(MRH_US, TICK_US);
  localparam int unsigned TMAX    = (HOLD_T > RETRY_T) ? HOLD_T : RETRY_T;
  localparam int unsigned TW      = cnt_width(TMAX);
  localparam bit          LIMITED = (RETRY_LIMIT != 0);
  localparam int unsigned RW      = cnt_width(LIMITED ? RETRY_LIMIT : 1);

  // Synchronised comparator and host inputs
  logic uv_s, ov_s, ocn_s, oci_s, drain_s, gok_s, mrh_s;
  hs_sync #(.W(7)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({mrh, gate_ok, drain_ok, oc_ins_flag, oc_norm_flag, ov_flag, uv_flag}),
    .q    ({mrh_s, gok_s, drain_s, oci_s, ocn_s, ov_s, uv_s})
  );

  hs_state_e     state;
  logic [TW-1:0] tmr;
  logic [RW-1:0] retry_cnt;
  logic          gate_q, pg_q, fail_q;

  // Named internal events
  logic win_ok, oc_sel, oc_trip, mrh_acc, hold_done, retry_done, at_limit;
  assign win_ok     = !uv_s && !ov_s;
  assign oc_sel     = pg_q ? ocn_s : oci_s;
  assign hold_done  = (tmr == TW'(HOLD_T));
  assign retry_done = (tmr == TW'(RETRY_T));
  assign at_limit   = LIMITED && (retry_cnt == RW'(RETRY_LIMIT));

  hs_persist #(.N(FILT_T)) u_oc_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .clr(state != ST_ON || !gate_q), .din(oc_sel), .hit(oc_trip)
  );

  hs_persist #(.N(MRH_T)) u_mrh_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .clr(1'b0), .din(mrh_s), .hit(mrh_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HOLD;
      tmr       <= '0;
      retry_cnt <= '0;
      fail_q    <= 1'b0;
    end else if (mrh_acc) begin
      state     <= ST_MRH;
      tmr       <= '0;
      retry_cnt <= '0;
      fail_q    <= 1'b0;
    end else begin
      case (state)
        ST_HOLD: begin
          if (!win_ok)        tmr <= '0;
          else if (hold_done) begin state <= ST_ON; tmr <= '0; end
          else if (tick)      tmr <= tmr + 1'b1;
        end
        ST_ON: begin
          if (oc_trip) begin
            tmr <= '0;
            if (at_limit) begin state <= ST_FAIL; fail_q <= 1'b1; end
            else          state <= ST_RETRY;
          end
        end
        ST_RETRY: begin
          if (retry_done) begin
            state <= ST_ON;
            tmr   <= '0;
            if (LIMITED) retry_cnt <= retry_cnt + 1'b1;
          end else if (tick) begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_FAIL: state <= ST_FAIL;
        ST_MRH: begin
          if (!mrh_s) begin state <= ST_HOLD; tmr <= '0; end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pg_q   <= 1'b0;
    end else begin
      gate_q <= (state == ST_ON) && win_ok && !mrh_s;
      pg_q   <= drain_s && gok_s;
    end
  end

  assign gate_en    = gate_q;
  assign pwr_good   = pg_q;
  assign retry_fail = fail_q;

  AST_HOLD_BEFORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !hold_done) |=> state != ST_ON); // R2
  AST_WINDOW_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !win_ok |=> !gate_en); // R3
  AST_PG_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(drain_s && gok_s) |=> !pwr_good); // R6
  AST_FAIL_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    retry_fail |=> !gate_en); // R8
  AST_MRH_CLEARS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    mrh_acc |=> !retry_fail); // R9
  AST_MRH_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mrh_s |=> !gate_en); // R10

  generate
    if (LIMITED) begin : g_bound
      AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        retry_cnt <= RW'(RETRY_LIMIT)); // R8
    end
  endgenerate
endmodule

// File: tb/hs_gate_seq_test.sv
module hs_gate_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic uv = 1'b1, ov = 1'b0, ocn = 1'b0, oci = 1'b0;
  logic dok = 1'b0, gok = 1'b0, mrh = 1'b0;
  logic gate, pg, fail, gate_inf, pg_inf, fail_inf;

  always #2 clk = ~clk; // 250 MHz

  hs_gate_seq #(.TICK_US(1), .HOLD_US(20), .RETRY_US(30), .FILT_US(5),
                .MRH_US(5), .RETRY_LIMIT(5)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv_flag(uv), .ov_flag(ov),
    .oc_norm_flag(ocn), .oc_ins_flag(oci), .drain_ok(dok), .gate_ok(gok),
    .mrh(mrh), .gate_en(gate), .pwr_good(pg), .retry_fail(fail));

  hs_gate_seq #(.TICK_US(1), .HOLD_US(20), .RETRY_US(30), .FILT_US(5),
                .MRH_US(5), .RETRY_LIMIT(0)) uut_inf (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv_flag(uv), .ov_flag(ov),
    .oc_norm_flag(ocn), .oc_ins_flag(oci), .drain_ok(dok), .gate_ok(gok),
    .mrh(mrh), .gate_en(gate_inf), .pwr_good(pg_inf), .retry_fail(fail_inf));

  typedef struct {
    string req;
    int    sel;
    logic  exp;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic pick(input int sel);
    case (sel)
      0: return gate;
      1: return pg;
      2: return fail;
      3: return gate_inf;
      default: return fail_inf;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver side: queue an expectation for the current cycle
  task automatic expect_out(input string req, input int sel, input logic exp);
    exp_t e;
    e.req = req; e.sel = sel; e.exp = exp;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, pick(e.sel), e.exp);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int rises;
    logic prev;
    step(3);
    expect_out("R1 gate in reset", 0, 1'b0);
    expect_out("R1 pg in reset", 1, 1'b0);
    expect_out("R1 fail in reset", 2, 1'b0);
    rst_n = 1'b1;
    step(1);
    expect_out("R1 gate after reset", 0, 1'b0);
    step(4);

    // R2: hold-off with an interruption
    uv = 1'b0;
    step(12);
    uv = 1'b1;
    step(3);
    uv = 1'b0;
    step(15);
    expect_out("R2 hold-off restarted", 0, 1'b0);
    step(15);
    expect_out("R2 gate on after hold-off", 0, 1'b1);

    // R3: window fault
    ov = 1'b1;
    step(4);
    expect_out("R3 overvoltage gate off", 0, 1'b0);
    ov = 1'b0;
    step(4);
    expect_out("R3 gate back without hold-off", 0, 1'b1);
    uv = 1'b1;
    step(4);
    expect_out("R3 undervoltage gate off", 0, 1'b0);
    uv = 1'b0;
    step(4);
    expect_out("R3 gate back after undervoltage", 0, 1'b1);

    // R4: normal flag ignored before power-good
    ocn = 1'b1;
    step(15);
    expect_out("R4 normal flag ignored during insertion", 0, 1'b1);
    ocn = 1'b0;

    // R5: short insertion pulse filtered
    oci = 1'b1;
    step(3);
    oci = 1'b0;
    step(10);
    expect_out("R5 short pulse ignored", 0, 1'b1);

    // R6: power-good
    dok = 1'b1;
    step(5);
    expect_out("R6 pg needs gate_ok", 1, 1'b0);
    gok = 1'b1;
    step(4);
    expect_out("R6 pg with both", 1, 1'b1);
    dok = 1'b0;
    step(4);
    expect_out("R6 pg drops on drain", 1, 1'b0);
    dok = 1'b1;
    step(4);
    expect_out("R6 pg back", 1, 1'b1);

    // R4/R7: normal flag trips after power-good, then retry
    ocn = 1'b1;
    step(12);
    expect_out("R4 normal flag trips after pg", 0, 1'b0);
    ocn = 1'b0;
    step(15);
    expect_out("R7 gate off during retry wait", 0, 1'b0);
    step(20);
    expect_out("R7 gate on after retry", 0, 1'b1);
    expect_out("R7 unbounded gate on after retry", 3, 1'b1);

    // R8: persistent fault exhausts retries
    ocn = 1'b1;
    rises = 0;
    prev = gate_inf;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (gate_inf && !prev) rises++;
      prev = gate_inf;
    end
    expect_out("R8 fail flag set", 2, 1'b1);
    expect_out("R8 gate off after limit", 0, 1'b0);
    expect_out("R8 unbounded never fails", 4, 1'b0);
    step(1);
    chk("R8 unbounded keeps retrying", (rises >= 5), 1'b1);

    // R9: fail persists after fault clears
    ocn = 1'b0;
    step(50);
    expect_out("R9 fail persists", 2, 1'b1);
    expect_out("R9 gate stays off", 0, 1'b0);

    // R10: short MRH pulse does not clear
    mrh = 1'b1;
    step(2);
    mrh = 1'b0;
    step(10);
    expect_out("R10 short mrh ignored", 2, 1'b1);

    // R9/R10: accepted MRH clears and restarts
    mrh = 1'b1;
    step(12);
    expect_out("R9 mrh clears fail", 2, 1'b0);
    expect_out("R10 gate off under mrh", 0, 1'b0);
    mrh = 1'b0;
    step(10);
    expect_out("R10 hold-off after mrh", 0, 1'b0);
    step(20);
    expect_out("R10 gate on after restart", 0, 1'b1);

    // R10: short pulse while on forces gate off, no hold-off
    mrh = 1'b1;
    step(3);
    expect_out("R10 mrh forces gate off", 0, 1'b0);
    mrh = 1'b0;
    step(5);
    expect_out("R10 gate back after short mrh", 0, 1'b1);

    step(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule